// File: doc/BRIEF.md
# Packed Narrowing Unit with Saturation

This unit takes two 64-bit packed operands, a destination operand and a source operand, and narrows every element of both into a single 64-bit packed result. Each element is clamped to the range of the narrower type instead of being truncated. An opcode byte picks one of three narrowings: signed 32-bit to signed 16-bit, signed 16-bit to signed 8-bit, or signed 16-bit to unsigned 8-bit. The source operand may come from a register or from memory. The unit does not care which, because operand fetch, addressing and the register file all sit outside it.

An operation is issued by raising `in_valid` with the opcode and both operands for one cycle. Exactly two clock cycles later the unit presents the result together with a write strobe for the destination register. A new operation may be issued on every cycle. When the opcode is not one of the three narrowing codes, the unit raises an illegal-operation flag and holds back the write strobe. It also returns the destination operand unchanged, so the destination keeps its value.

Top module: `pack_saturate_unit`

## Requirements
- R1: Opcode 0x6B narrows each signed 32-bit element to a signed 16-bit element. Values above 32767 become 0x7FFF, values below -32768 become 0x8000, and all other values keep their low 16 bits.
- R2: Opcode 0x63 narrows each signed 16-bit element to a signed 8-bit element. Values above 127 become 0x7F, values below -128 become 0x80, and all other values keep their low 8 bits.
- R3: Opcode 0x67 reads each 16-bit element as signed and narrows it to an unsigned byte. Negative values become 0x00, values above 255 become 0xFF, and values from 0 to 255 pass through unchanged.
- R4: The narrowed elements of the destination operand fill result bits [31:0], and the narrowed elements of the source operand fill bits [63:32].
- R5: Within each half, element order is kept: input element i of an operand lands in output element i of that operand's half (16-bit slots for 0x6B, byte slots for 0x63 and 0x67).
- R6: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high and is low otherwise. One operation is accepted per cycle, with no gaps required between operations.
- R7: For any other opcode, `out_illegal` is high and `out_write` is low. `out_data` equals the destination operand, so the destination register is left unchanged.
- R8: While reset is asserted (active-low `rst_n`), `out_valid`, `out_write`, `out_illegal` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for one operation |
| opcode | input | 8 | Second opcode byte selecting the narrowing |
| dst_op | input | 64 | Destination operand (low half of result) |
| src_op | input | 64 | Source operand, register or memory (high half of result) |
| out_valid | output | 1 | Result present, two cycles after issue |
| out_write | output | 1 | Write strobe for the destination register |
| out_illegal | output | 1 | Opcode was not a narrowing code |
| out_data | output | 64 | Narrowed result, or destination operand when illegal |

## Verification
A wrong internal state here is a mis-decoded mode or stale first-stage operands. Either one shows up at `out_data` on the very cycle the affected result is presented, two cycles after issue. Wrong clamp limits only show up on out-of-range elements, and a swapped half or lane only shows up when the elements in an operand differ. The stimulus therefore sweeps boundary values right around each limit and rotates them so that every element in an operand is distinct. Operations are issued back to back, so a pipeline slip shows up as a result attached to the wrong issue cycle.

// File: rtl/pack_saturate_unit.sv
module pack_saturate_unit #(
  parameter logic [7:0] OPC_DW_SW = 8'h6B,
  parameter logic [7:0] OPC_W_SB  = 8'h63,
  parameter logic [7:0] OPC_W_UB  = 8'h67
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [63:0] dst_op,
  input  logic [63:0] src_op,
  output logic        out_valid,
  output logic        out_write,
  output logic        out_illegal,
  output logic [63:0] out_data
);

  localparam logic [1:0] M_DW_SW = 2'd0;
  localparam logic [1:0] M_W_SB  = 2'd1;
  localparam logic [1:0] M_W_UB  = 2'd2;
  localparam logic [1:0] M_BAD   = 2'd3;

  function automatic logic [15:0] clamp_s16(input logic signed [31:0] v);
    if (v > 32'sd32767)       return 16'h7FFF;
    else if (v < -32'sd32768) return 16'h8000;
    else                      return v[15:0];
  endfunction

  function automatic logic [7:0] clamp_s8(input logic signed [15:0] v);
    if (v > 16'sd127)       return 8'h7F;
    else if (v < -16'sd128) return 8'h80;
    else                    return v[7:0];
  endfunction

  function automatic logic [7:0] clamp_u8(input logic signed [15:0] v);
    if (v < 16'sd0)        return 8'h00;
    else if (v > 16'sd255) return 8'hFF;
    else                   return v[7:0];
  endfunction

  logic [1:0] dec_mode;
  always_comb begin
    case (opcode)
      OPC_DW_SW: dec_mode = M_DW_SW;
      OPC_W_SB:  dec_mode = M_W_SB;
      OPC_W_UB:  dec_mode = M_W_UB;
      default:   dec_mode = M_BAD;
    endcase
  end

  logic        s1_valid;
  logic [1:0]  s1_mode;
  logic [63:0] s1_dst, s1_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= M_BAD;
      s1_dst   <= '0;
      s1_src   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_mode <= dec_mode;
        s1_dst  <= dst_op;
        s1_src  <= src_op;
      end
    end
  end

  logic [63:0] opnd [2];
  assign opnd[0] = s1_dst;
  assign opnd[1] = s1_src;

  logic [63:0] res_sw, res_sb, res_ub;

  for (genvar g = 0; g < 2; g++) begin : g_half
    for (genvar w = 0; w < 2; w++) begin : g_dw
      assign res_sw[g*32 + w*16 +: 16] = clamp_s16(opnd[g][w*32 +: 32]);
    end
    for (genvar b = 0; b < 4; b++) begin : g_w
      assign res_sb[g*32 + b*8 +: 8] = clamp_s8(opnd[g][b*16 +: 16]);
      assign res_ub[g*32 + b*8 +: 8] = clamp_u8(opnd[g][b*16 +: 16]);
    end
  end

  logic [63:0] res_sel;
  always_comb begin
    case (s1_mode)
      M_DW_SW: res_sel = res_sw;
      M_W_SB:  res_sel = res_sb;
      M_W_UB:  res_sel = res_ub;
      default: res_sel = s1_dst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_write   <= 1'b0;
      out_illegal <= 1'b0;
      out_data    <= '0;
    end else begin
      out_valid   <= s1_valid;
      out_write   <= s1_valid && (s1_mode != M_BAD);
      out_illegal <= s1_valid && (s1_mode == M_BAD);
      if (s1_valid) out_data <= res_sel;
    end
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_illegal == ($past(opcode, 2) != OPC_DW_SW &&
                                   $past(opcode, 2) != OPC_W_SB &&
                                   $past(opcode, 2) != OPC_W_UB)));

  assert_dst_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_data == $past(dst_op, 2)));

  assert_sw_high_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_write && $past(opcode, 2) == OPC_DW_SW &&
     $signed($past(src_op[31:0], 2)) > 32'sd32767) |-> (out_data[47:32] == 16'h7FFF));

  assert_sb_low_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_write && $past(opcode, 2) == OPC_W_SB &&
     $signed($past(dst_op[15:0], 2)) < -16'sd128) |-> (out_data[7:0] == 8'h80));

  assert_ub_negative_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_write && $past(opcode, 2) == OPC_W_UB && $past(dst_op[15], 2))
      |-> (out_data[7:0] == 8'h00));

endmodule

// File: tb/test_pack_saturate_unit.sv
module test_pack_saturate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [63:0] dst_op = '0;
  logic [63:0] src_op = '0;
  logic        out_valid, out_write, out_illegal;
  logic [63:0] out_data;

  pack_saturate_unit i_pack_saturate_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .dst_op(dst_op), .src_op(src_op), .out_valid(out_valid),
    .out_write(out_write), .out_illegal(out_illegal), .out_data(out_data)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          v, w, il;
    logic [63:0] d;
    string       tag;
  } exp_t;
  exp_t e0, e1;

  function automatic int wval(int i);
    case (i % 13)
      0: return 0;       1: return 1;      2: return -1;
      3: return 127;     4: return 128;    5: return -128;
      6: return -129;    7: return 255;    8: return 256;
      9: return 32767;   10: return -32768; 11: return 100;
      default: return -100;
    endcase
  endfunction

  function automatic int dval(int i);
    case (i % 12)
      0: return 0;           1: return 1;        2: return -1;
      3: return 32767;       4: return 32768;    5: return -32768;
      6: return -32769;      7: return 2147483647;
      8: return -2147483647 - 1;                 9: return 70000;
      10: return -70000;     default: return 12345;
    endcase
  endfunction

  function automatic logic [15:0] m_s16(int v);
    int r = v;
    if (v > 32767) r = 32767;
    if (v < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [7:0] m_s8(int v);
    int r = v;
    if (v > 127) r = 127;
    if (v < -128) r = -128;
    return r[7:0];
  endfunction

  function automatic logic [7:0] m_u8(int v);
    int r = v;
    if (v > 255) r = 255;
    if (v < 0) r = 0;
    return r[7:0];
  endfunction

  function automatic exp_t model(bit v, logic [7:0] op, logic [63:0] d, logic [63:0] s);
    exp_t e;
    logic [63:0] both [2];
    both[0] = d; both[1] = s;
    e.v = v; e.w = 0; e.il = 0; e.d = d; e.tag = "R6";
    if (!v) return e;
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 4; k++) begin
        int wv = int'($signed(both[h][k*16 +: 16]));
        if (op == 8'h63) e.d[h*32 + k*8 +: 8] = m_s8(wv);
        if (op == 8'h67) e.d[h*32 + k*8 +: 8] = m_u8(wv);
      end
      for (int k = 0; k < 2; k++)
        if (op == 8'h6B) e.d[h*32 + k*16 +: 16] = m_s16(int'($signed(both[h][k*32 +: 32])));
    end
    case (op)
      8'h6B: begin e.w = 1; e.tag = "R1/R4/R5/R6"; end
      8'h63: begin e.w = 1; e.tag = "R2/R4/R5/R6"; end
      8'h67: begin e.w = 1; e.tag = "R3/R4/R5/R6"; end
      default: begin e.il = 1; e.d = d; e.tag = "R7"; end
    endcase
    return e;
  endfunction

  task automatic check_out();
    checks++;
    if (out_valid !== e1.v) begin
      errors++;
      $display("FAIL %s out_valid=%0b expected %0b", e1.tag, out_valid, e1.v);
    end else if (e1.v && (out_write !== e1.w || out_illegal !== e1.il || out_data !== e1.d)) begin
      errors++;
      $display("FAIL %s write/illegal/data=%0b/%0b/%h expected %0b/%0b/%h",
               e1.tag, out_write, out_illegal, out_data, e1.w, e1.il, e1.d);
    end
  endtask

  task automatic step(bit v, logic [7:0] op, logic [63:0] d, logic [63:0] s);
    @(negedge clk);
    check_out();
    e1 = e0;
    e0 = model(v, op, d, s);
    in_valid = v; opcode = op; dst_op = d; src_op = s;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    e0 = model(0, 0, 0, 0); e1 = e0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_write !== 0 || out_illegal !== 0 || out_data !== 64'd0) begin
      errors++;
      $display("FAIL R8 outputs %0b/%0b/%0b/%h expected 0/0/0/0",
               out_valid, out_write, out_illegal, out_data);
    end
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < 13; a++)
      for (int b = 0; b < 13; b++) begin
        logic [63:0] d, s;
        for (int k = 0; k < 4; k++) begin
          int x = wval(a + 3*k), y = wval(b + 5*k);
          d[k*16 +: 16] = x[15:0];
          s[k*16 +: 16] = y[15:0];
        end
        step(1, 8'h63, d, s);
        step(1, 8'h67, d, s);
        if ((a + b) % 7 == 0) step(0, 8'h63, 64'd0, 64'd0);
      end

    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 12; b++) begin
        logic [63:0] d, s;
        for (int k = 0; k < 2; k++) begin
          int x = dval(a + 5*k + 1), y = dval(b + 7*k + 2);
          d[k*32 +: 32] = x;
          s[k*32 +: 32] = y;
        end
        step(1, 8'h6B, d, s);
      end

    for (int op = 0; op < 256; op++) begin
      logic [63:0] d = {8{op[7:0] ^ 8'hA5}} + 64'h0123_4567_89AB_CDEF;
      logic [63:0] s = ~d;
      step(1, op[7:0], d, s);
      if (op % 16 == 0) step(0, 8'h00, 64'd0, 64'd0);
    end

    step(0, 8'h00, 64'd0, 64'd0);
    step(0, 8'h00, 64'd0, 64'd0);
    step(0, 8'h00, 64'd0, 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule